// File: doc/BRIEF.md
# Timer Time-Base with Shadowed Prescaler

This block is the counting core of a general-purpose 16-bit timer. A prescaler divides the timer clock by a programmable divisor plus one. Each prescaler tick moves the main counter one step. The counter can count up, count down, or count up and then down, and it raises an update event each time it wraps or turns around. That event produces a one-cycle `update_o` pulse and sets a sticky flag.

Software reaches the block through a simple write port. The port selects the live count, the period or the divisor. The period and divisor each sit behind a working copy. The divisor's working copy changes only at an update event. The period's working copy does the same when period buffering is on; with buffering off, the period register is used directly.

Update events come from counter wrap, from a software trigger, or from an external slave reset. Two control bits decide which of these sources count and whether updates happen at all. The count enable is registered, so counting starts and stops one clock after the enable input changes.

Top module: `tbase_timer`

## Requirements
- R1: After reset the count is 0, the sticky flag is 0, `update_o` is 0, the working divisor is 0 and the period register and its working copy are 0xFFFF.
- R2: The internal run state follows `run_en` one clock later. The first count step after `run_en` rises happens no earlier than the second rising edge. After `run_en` falls, at most one further step occurs.
- R3: While running, the counter takes one step every (working divisor + 1) clocks. Every update event restarts the prescaler from 0. Without a tick, a count write or a slave reset, the count holds.
- R4: A divisor write (`wr_sel`=2) reaches the working divisor only at an update event. A change made mid-period keeps the old division until the next wrap, and the new division applies from then on.
- R5: With `per_buf`=0, a period write (`wr_sel`=1) takes effect on the next clock. With `per_buf`=1, the working period changes only at an update event.
- R6: With `cnt_mode`=0 (up), the counter runs from 0 to the working period, then returns to 0 with an update event.
- R7: With `cnt_mode`=1 (down), the counter steps down to 0, then reloads the working period with an update event.
- R8: With `cnt_mode`=2 or 3 (up/down), the counter rises to the period, then falls to 0. An update event is raised at each turnaround.
- R9: With `upd_src`=0, a wrap, `sw_update` or `slave_rst` each produce an update event. With `upd_src`=1, only a wrap does, and the other two leave the working divisor untouched.
- R10: With `upd_dis`=1 no update event occurs. `update_o` stays 0, the flag is not set, and neither working copy is reloaded.
- R11: A count write (`wr_sel`=0) replaces the count on the next clock and is readable on `count_o`. It has priority over a tick in the same cycle, and it cancels that cycle's wrap event.
- R12: The sticky flag is set by every update event and cleared by `flag_clr`. If both occur in the same cycle, set wins.
- R13: `slave_rst` clears the prescaler and sets the count to 0 in up and up/down modes, or to the working period in down mode, whether or not updates are enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_en | input | 1 | Count enable, registered before use |
| cnt_mode | input | 2 | 0 up, 1 down, 2/3 up/down |
| per_buf | input | 1 | 1 = period changes only at update events |
| upd_dis | input | 1 | 1 = suppress all update events |
| upd_src | input | 1 | 1 = only wrap produces an update event |
| sw_update | input | 1 | Software update trigger, one cycle |
| slave_rst | input | 1 | External counter reset, one cycle |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | 0 count, 1 period, 2 divisor, 3 none |
| wr_data | input | 16 | Write data |
| flag_clr | input | 1 | Clears the sticky flag |
| count_o | output | 16 | Live count |
| update_o | output | 1 | Update event pulse, same cycle as its cause |
| ovf_flag_o | output | 1 | Sticky update flag |

## Verification
A count write can arrive in the same cycle as the prescaler tick that would wrap the counter. The bench lets an up-count reach the period, then drives a count write on the pending-wrap cycle. It then judges that `update_o` drops at once, that the written value and not 0 appears on the next clock, and that the flag stays clear. A flag clear that coincides with a software update is checked the same way: the flag must read as set afterwards.

// File: rtl/tbase_pkg.sv
package tbase_pkg;
  localparam int CNT_W = 16;
  typedef logic [CNT_W-1:0] cnt_t;

  localparam logic [1:0] MODE_UP   = 2'd0;
  localparam logic [1:0] MODE_DOWN = 2'd1;

  localparam logic [1:0] SEL_CNT = 2'd0;
  localparam logic [1:0] SEL_PER = 2'd1;
  localparam logic [1:0] SEL_DIV = 2'd2;

  // true when the next tick wraps or turns the counter around
  function automatic logic turn_point(logic [1:0] mode, logic going_down, cnt_t c, cnt_t p);
    case (mode)
      MODE_UP:   turn_point = (c >= p);
      MODE_DOWN: turn_point = (c == '0);
      default:   turn_point = going_down ? (c == '0) : (c >= p);
    endcase
  endfunction

  function automatic cnt_t next_count(logic [1:0] mode, logic going_down, cnt_t c, cnt_t p);
    logic t;
    t = turn_point(mode, going_down, c, p);
    case (mode)
      MODE_UP:   next_count = t ? '0 : c + 1'b1;
      MODE_DOWN: next_count = t ? p : c - 1'b1;
      default: begin
        if (!going_down) next_count = t ? ((p == '0) ? '0 : p - 1'b1) : c + 1'b1;
        else             next_count = t ? ((p == '0) ? '0 : cnt_t'(1)) : c - 1'b1;
      end
    endcase
  endfunction

  function automatic logic next_dir(logic [1:0] mode, logic going_down, cnt_t c, cnt_t p);
    if (mode == MODE_UP || mode == MODE_DOWN) next_dir = 1'b0;
    else next_dir = turn_point(mode, going_down, c, p) ? ~going_down : going_down;
  endfunction
endpackage

// File: rtl/tbase_prescaler.sv
module tbase_prescaler
  import tbase_pkg::*;
#(
  parameter int W = CNT_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run_q,
  input  logic         clear,
  input  logic [W-1:0] div_sh,
  output logic         tick
);
  logic [W-1:0] psc;

  assign tick = run_q && (psc >= div_sh);

  always_ff @(posedge clk) begin
    if (!rst_n)      psc <= '0;
    else if (clear)  psc <= '0;
    else if (tick)   psc <= '0;
    else if (run_q)  psc <= psc + 1'b1;
  end

  AST_PSC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (psc == '0)); // R3
  AST_PSC_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !clear) |=> $stable(psc)); // R2
endmodule

// File: rtl/tbase_shadows.sv
module tbase_shadows
  import tbase_pkg::*;
#(
  parameter int W = CNT_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_per,
  input  logic         wr_div,
  input  logic [W-1:0] wr_data,
  input  logic         per_buf,
  input  logic         load,
  output logic [W-1:0] per_eff,
  output logic [W-1:0] div_sh
);
  logic [W-1:0] per_reg, per_sh, div_reg;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      per_reg <= '1;
      div_reg <= '0;
    end else begin
      if (wr_per) per_reg <= wr_data;
      if (wr_div) div_reg <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      per_sh <= '1;
      div_sh <= '0;
    end else if (load) begin
      per_sh <= per_reg;
      div_sh <= div_reg;
    end
  end

  assign per_eff = per_buf ? per_sh : per_reg;

  AST_DIV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(div_sh)); // R4
  AST_PER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(per_sh)); // R5
endmodule

// File: rtl/tbase_counter.sv
module tbase_counter
  import tbase_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode,
  input  logic       tick,
  input  cnt_t       per_eff,
  input  logic       cnt_wr,
  input  cnt_t       wr_data,
  input  logic       slave_rst,
  output cnt_t       cnt,
  output logic       ovf_evt
);
  logic going_down;

  assign ovf_evt = tick && !cnt_wr && !slave_rst
                   && turn_point(mode, going_down, cnt, per_eff);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt        <= '0;
      going_down <= 1'b0;
    end else if (slave_rst) begin
      cnt        <= (mode == MODE_DOWN) ? per_eff : '0;
      going_down <= 1'b0;
    end else if (cnt_wr) begin
      cnt <= wr_data;
    end else if (tick) begin
      cnt        <= next_count(mode, going_down, cnt, per_eff);
      going_down <= next_dir(mode, going_down, cnt, per_eff);
    end
  end

  AST_UP_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_evt && mode == MODE_UP) |=> (cnt == '0)); // R6
  AST_DOWN_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_evt && mode == MODE_DOWN) |=> (cnt == $past(per_eff))); // R7
  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_wr && !slave_rst) |=> (cnt == $past(wr_data))); // R11
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !cnt_wr && !slave_rst) |=> $stable(cnt)); // R3
endmodule

// File: rtl/tbase_timer.sv
module tbase_timer
  import tbase_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        run_en,
  input  logic [1:0]  cnt_mode,
  input  logic        per_buf,
  input  logic        upd_dis,
  input  logic        upd_src,
  input  logic        sw_update,
  input  logic        slave_rst,
  input  logic        wr_en,
  input  logic [1:0]  wr_sel,
  input  logic [15:0] wr_data,
  input  logic        flag_clr,
  output logic [15:0] count_o,
  output logic        update_o,
  output logic        ovf_flag_o
);
  logic run_q, tick, ovf_evt, upd_evt, side_evt;
  cnt_t per_eff, div_sh;

  always_ff @(posedge clk) begin
    if (!rst_n) run_q <= 1'b0;
    else        run_q <= run_en;
  end

  assign side_evt = !upd_src && (sw_update || slave_rst);
  assign upd_evt  = !upd_dis && (ovf_evt || side_evt);
  assign update_o = upd_evt;

  tbase_shadows u_shadows (
    .clk(clk), .rst_n(rst_n),
    .wr_per(wr_en && wr_sel == SEL_PER),
    .wr_div(wr_en && wr_sel == SEL_DIV),
    .wr_data(wr_data), .per_buf(per_buf), .load(upd_evt),
    .per_eff(per_eff), .div_sh(div_sh)
  );

  tbase_prescaler u_psc (
    .clk(clk), .rst_n(rst_n), .run_q(run_q),
    .clear(upd_evt || slave_rst), .div_sh(div_sh), .tick(tick)
  );

  tbase_counter u_cnt (
    .clk(clk), .rst_n(rst_n), .mode(cnt_mode), .tick(tick),
    .per_eff(per_eff), .cnt_wr(wr_en && wr_sel == SEL_CNT),
    .wr_data(wr_data), .slave_rst(slave_rst),
    .cnt(count_o), .ovf_evt(ovf_evt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)        ovf_flag_o <= 1'b0;
    else if (upd_evt)  ovf_flag_o <= 1'b1;
    else if (flag_clr) ovf_flag_o <= 1'b0;
  end

  AST_ENABLE_LAG: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> !tick); // R2
  AST_UPD_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    upd_dis |=> $stable(div_sh)); // R10
  AST_SRC_ONLY_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_src && !ovf_evt) |=> $stable(div_sh)); // R9
  AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    update_o |=> ovf_flag_o); // R12
endmodule

// File: tb/sim_tbase_timer.sv
module sim_tbase_timer;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run_en = 0, per_buf = 0, upd_dis = 0, upd_src = 0;
  logic sw_update = 0, slave_rst = 0, wr_en = 0, flag_clr = 0;
  logic [1:0] cnt_mode = 2'd0, wr_sel = 2'd0;
  logic [15:0] wr_data = '0;
  logic [15:0] count_o;
  logic update_o, ovf_flag_o;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tbase_timer u0 (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .cnt_mode(cnt_mode),
    .per_buf(per_buf), .upd_dis(upd_dis), .upd_src(upd_src),
    .sw_update(sw_update), .slave_rst(slave_rst), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_data(wr_data), .flag_clr(flag_clr),
    .count_o(count_o), .update_o(update_o), .ovf_flag_o(ovf_flag_o)
  );

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] sel, logic [15:0] d);
    wr_en = 1; wr_sel = sel; wr_data = d;
    step();
    wr_en = 0;
  endtask

  task automatic pulse_sw();
    sw_update = 1; step(); sw_update = 0;
  endtask

  task automatic clear_flag();
    flag_clr = 1; step(); flag_clr = 0;
  endtask

  task automatic gap(output int n);
    logic [15:0] v;
    v = count_o; n = 0;
    do begin step(); n++; end while (count_o == v && n < 200);
  endtask

  task automatic run_to_wrap(output int peak, output logic saw);
    peak = 0; saw = 0;
    for (int i = 0; i < 400; i++) begin
      if (update_o) saw = 1;
      step();
      if (count_o > peak) peak = count_o;
      if (count_o == 0 && peak != 0) break;
    end
  endtask

  task automatic setup(logic [1:0] m, logic [15:0] p, logic [15:0] d);
    run_en = 0; step(); step();
    per_buf = 0; upd_dis = 0; upd_src = 0; cnt_mode = m;
    wr(2'd1, p); wr(2'd2, d); pulse_sw(); wr(2'd0, 16'd0); clear_flag();
  endtask

  task automatic t_reset();
    check("R1 count", count_o, 0);
    check("R1 flag", ovf_flag_o, 0);
    check("R1 update", update_o, 0);
  endtask

  task automatic t_enable_and_up();
    wr(2'd1, 16'd3);                 // R5 unbuffered period applies at once
    run_en = 1; #1;
    check("R2 before edge", count_o, 0);
    step(); check("R2 one clock lag", count_o, 0);
    step(); check("R2 first step", count_o, 1);
    step(); step();
    check("R6 at period", count_o, 3);
    check("R6 wrap event", update_o, 1);
    step();
    check("R6 back to zero", count_o, 0);
    check("R12 flag set", ovf_flag_o, 1);
    run_en = 0;
    step(); step(); step();
    check("R2 stop after one", count_o, 1);
    clear_flag();
    check("R12 flag cleared", ovf_flag_o, 0);
  endtask

  task automatic t_prescale();
    int n;
    wr(2'd2, 16'd2);
    sw_update = 1; #1;
    check("R9 sw update event", update_o, 1);
    step(); sw_update = 0;
    wr(2'd0, 16'd0);
    run_en = 1;
    gap(n); gap(n);
    check("R3 divide by 3", n, 3);
    wr(2'd2, 16'd0);                 // mid-period change
    gap(n);                          // to 3, partial
    gap(n);
    check("R4 old division to wrap", n, 3);
    check("R4 wrapped", count_o, 0);
    gap(n);
    check("R4 new division after wrap", n, 1);
  endtask

  task automatic t_buffered_period();
    int pk; logic s;
    setup(2'd0, 16'd3, 16'd0);
    per_buf = 1;
    wr(2'd1, 16'd6);
    run_en = 1;
    run_to_wrap(pk, s);
    check("R5 old period held", pk, 3);
    run_to_wrap(pk, s);
    check("R5 new period after update", pk, 6);
  endtask

  task automatic t_update_disable();
    int pk; logic s;
    clear_flag();
    upd_dis = 1;
    wr(2'd1, 16'd2); wr(2'd2, 16'd1);
    run_to_wrap(pk, s);
    check("R10 period kept", pk, 6);
    run_to_wrap(pk, s);
    check("R10 period kept again", pk, 6);
    check("R10 no update pulse", s, 0);
    check("R10 flag untouched", ovf_flag_o, 0);
    upd_dis = 0;
    run_to_wrap(pk, s);
    run_to_wrap(pk, s);
    check("R10 reload resumes", pk, 2);
  endtask

  task automatic t_sources();
    int n;
    setup(2'd0, 16'd100, 16'd0);
    upd_src = 1;
    wr(2'd2, 16'd3);
    sw_update = 1; #1;
    check("R9 sw ignored", update_o, 0);
    step(); sw_update = 0;
    check("R9 flag not set", ovf_flag_o, 0);
    wr(2'd0, 16'd5);
    slave_rst = 1; #1;
    check("R9 slave ignored", update_o, 0);
    step(); slave_rst = 0;
    check("R13 slave clears count", count_o, 0);
    wr(2'd1, 16'd2);
    run_en = 1; step();
    gap(n);
    check("R9 divisor not loaded", n, 1);
    for (int i = 0; i < 20 && count_o != 2; i++) step();
    check("R9 wrap event with select", update_o, 1);
    step();
    gap(n);
    check("R3 prescaler restart after update", n, 4);
    upd_src = 0;
    run_en = 0; step(); step();
    slave_rst = 1; #1;
    check("R9 slave event", update_o, 1);
    step(); slave_rst = 0;
  endtask

  task automatic t_down();
    int ex[6] = '{4, 3, 2, 1, 0, 4};
    setup(2'd1, 16'd4, 16'd0);
    run_en = 1; step();
    check("R7 underflow from zero", update_o, 1);
    foreach (ex[i]) begin
      step();
      check("R7 down count", count_o, ex[i]);
      check("R7 event only at zero", update_o, (ex[i] == 0) ? 1 : 0);
    end
    run_en = 0; step(); step();
    wr(2'd0, 16'd1);
    slave_rst = 1; step(); slave_rst = 0;
    check("R13 down reload", count_o, 4);
  endtask

  task automatic t_updown();
    int ex[7] = '{1, 2, 3, 2, 1, 0, 1};
    int ev[7] = '{0, 0, 1, 0, 0, 1, 0};
    setup(2'd2, 16'd3, 16'd0);
    run_en = 1; step();
    check("R8 start", count_o, 0);
    check("R8 no event at start", update_o, 0);
    foreach (ex[i]) begin
      step();
      check("R8 count", count_o, ex[i]);
      check("R8 turnaround event", update_o, ev[i]);
    end
  endtask

  task automatic t_collide();
    setup(2'd0, 16'd3, 16'd0);
    run_en = 1;
    for (int i = 0; i < 20 && count_o != 3; i++) step();
    check("R6 pending wrap", update_o, 1);
    wr_en = 1; wr_sel = 2'd0; wr_data = 16'd1; #1;
    check("R11 write cancels wrap", update_o, 0);
    step(); wr_en = 0;
    check("R11 write wins over tick", count_o, 1);
    check("R11 flag stays clear", ovf_flag_o, 0);
    run_en = 0; step(); step();
    wr(2'd0, 16'h1234);
    check("R11 readback", count_o, 16'h1234);
    wr(2'd3, 16'h0055);
    check("R11 unused select ignored", count_o, 16'h1234);
    sw_update = 1; flag_clr = 1; step(); sw_update = 0; flag_clr = 0;
    check("R12 set beats clear", ovf_flag_o, 1);
    clear_flag();
    check("R12 clear", ovf_flag_o, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    step();
    t_reset();
    t_enable_and_up();
    t_prescale();
    t_buffered_period();
    t_update_disable();
    t_sources();
    t_down();
    t_updown();
    t_collide();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule